// File: doc/BRIEF.md
# Flash Sector Protection Controller

This block keeps one protection bit for each of the sixteen 64-kilobyte sectors of a 1-megabyte serial flash array and decides, for every program or erase request, whether the operation may go ahead. Protection commands set or clear the bit of one sector, or set or clear all sixteen bits together. A hardware write-protect input freezes the protected state: while it is high, nothing can become unprotected, but sectors can still be protected.

A program or erase request arrives as an address and an operation kind. The kind is a page program of up to 256 bytes, an erase of 4, 32 or 64 kilobytes, or a full-chip erase. The block answers one cycle later with a result strobe and an ok bit. A request also needs a one-shot write-enable flag. That flag is armed by a separate strobe and is consumed by every request, whether the request is accepted or not. Any sector's protection bit can be read combinationally through a status port.

Top module: `sector_guard`

## Requirements
- R1: After synchronous reset, all sixteen sectors read as protected (stat_prot = 1 for every stat_sector).
- R2: Command code 2'b00 (protect one) sets the bit of the sector selected by cmd_addr[19:16] and leaves the other fifteen bits unchanged.
- R3: Command code 2'b01 (unprotect one) clears the bit of the sector selected by cmd_addr[19:16] and leaves the other bits unchanged.
- R4: Command code 2'b10 sets all sixteen bits, and command code 2'b11 clears all sixteen bits.
- R5: While hw_lock is 1, commands 2'b01 and 2'b11 have no effect on any bit, and commands 2'b00 and 2'b10 still take effect.
- R6: A request is rejected unless the write-enable flag is set. A wen_set pulse sets the flag from the next cycle on. Every op_valid cycle clears the flag, unless wen_set is high in that same cycle. A request that arrives together with wen_set sees the flag as it stood before that cycle.
- R7: Some kinds are accepted only if the sector addressed by op_addr[19:16] is unprotected. These kinds are: program (3'b000), 4-kilobyte erase (3'b001), 32-kilobyte erase (3'b010) and 64-kilobyte erase (3'b011). For a 4-kilobyte or 32-kilobyte erase, the sector is the one that holds the aligned block.
- R8: A full-chip erase (3'b100) is accepted only if all sixteen sectors are unprotected.
- R9: res_valid pulses exactly one cycle after each op_valid cycle and is low otherwise. The decision uses the protection bits as they stood before any command given in the same cycle.
- R10: stat_prot combinationally shows the protection bit of the sector selected by stat_sector.
- R11: Operation kind codes 3'b101, 3'b110 and 3'b111 are always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Protection command strobe |
| cmd_op | input | 2 | Protection command code |
| cmd_addr | input | 20 | Address that selects the sector for single-sector commands |
| hw_lock | input | 1 | Hardware write-protect; blocks every unprotect while high |
| wen_set | input | 1 | Arms the one-shot write-enable flag |
| op_valid | input | 1 | Program or erase request strobe |
| op_kind | input | 3 | Operation kind code |
| op_addr | input | 20 | Target address of the request |
| stat_sector | input | 4 | Sector whose protection bit is shown |
| stat_prot | output | 1 | Protection bit of the selected sector |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| res_ok | output | 1 | 1 when the request was accepted |

## Verification
The bench first goes after address decoding. It sends 4K, 32K and 64K erases at addresses near a sector edge. A design that picked the sector from the wrong bits would then accept an erase of a protected neighbour. It also tests the write-enable flag when the strobe and a request arrive in the same cycle, and again when a second request follows without re-arming; a flag with the wrong priority would let both requests through. It unprotects everything under hw_lock, which a lock wired only to single-sector commands would fail to block. It also issues a protect command in the same cycle as a request to that sector, which a design reading the updated bits would reject. Full-chip erase is tried with exactly one sector protected, and undefined kind codes are tried on an unprotected sector.

// File: rtl/sg_pkg.sv
package sg_pkg;

    localparam int NUM_SECTORS = 16;
    localparam int SECTOR_BITS = 16;
    localparam int ADDR_W      = 20;
    localparam int IDX_W       = $clog2(NUM_SECTORS);
    localparam int KIND_W      = 3;

    typedef enum logic [1:0] {
        CMD_PROT_ONE   = 2'b00,
        CMD_UNPROT_ONE = 2'b01,
        CMD_PROT_ALL   = 2'b10,
        CMD_UNPROT_ALL = 2'b11
    } prot_cmd_e;

    typedef enum logic [KIND_W-1:0] {
        OP_PROGRAM    = 3'b000,
        OP_ERASE_4K   = 3'b001,
        OP_ERASE_32K  = 3'b010,
        OP_ERASE_64K  = 3'b011,
        OP_ERASE_CHIP = 3'b100
    } op_kind_e;

    typedef struct packed {
        logic valid;
        logic ok;
    } op_result_t;

    // log2 of the byte span a request touches inside one sector
    function automatic int span_log2(input logic [KIND_W-1:0] kind);
        case (kind)
            OP_ERASE_4K:  return 12;
            OP_ERASE_32K: return 15;
            OP_ERASE_64K: return 16;
            default:      return 8;
        endcase
    endfunction

    // base of the naturally aligned block the request covers
    function automatic logic [ADDR_W-1:0] block_base(input logic [ADDR_W-1:0] addr,
                                                     input logic [KIND_W-1:0] kind);
        logic [ADDR_W-1:0] mask;
        mask = ~((ADDR_W'(1) << span_log2(kind)) - ADDR_W'(1));
        return addr & mask;
    endfunction

    function automatic logic [IDX_W-1:0] sector_of(input logic [ADDR_W-1:0] addr);
        return addr[SECTOR_BITS +: IDX_W];
    endfunction

endpackage

// File: rtl/sg_prot_map.sv
module sg_prot_map
    import sg_pkg::*;
#(
    parameter int N   = NUM_SECTORS,
    parameter int IW  = IDX_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  prot_cmd_e       cmd,
    input  logic [IW-1:0]   cmd_idx,
    input  logic            hw_lock,
    output logic [N-1:0]    prot_bits
);

    localparam logic [N-1:0] ONE_HOT_BASE = N'(1);

    for (genvar g = 0; g < N; g++) begin : g_sector
        logic hit;
        assign hit = (cmd_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                prot_bits[g] <= 1'b1;
            end else if (cmd_valid) begin
                case (cmd)
                    CMD_PROT_ONE:   if (hit) prot_bits[g] <= 1'b1;
                    CMD_UNPROT_ONE: if (hit && !hw_lock) prot_bits[g] <= 1'b0;
                    CMD_PROT_ALL:   prot_bits[g] <= 1'b1;
                    CMD_UNPROT_ALL: if (!hw_lock) prot_bits[g] <= 1'b0;
                    default:        ;
                endcase
            end
        end
    end

    assert_reset_protected_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&prot_bits));

    assert_single_isolated_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd == CMD_PROT_ONE || cmd == CMD_UNPROT_ONE)) |=>
        (((prot_bits ^ $past(prot_bits)) & ~(ONE_HOT_BASE << $past(cmd_idx))) == '0));

    assert_unprot_one_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == CMD_UNPROT_ONE && !hw_lock) |=> !prot_bits[$past(cmd_idx)]);

    assert_prot_all_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == CMD_PROT_ALL) |=> (&prot_bits));

    assert_lock_holds_R5: assert property (@(posedge clk) disable iff (rst)
        hw_lock |=> (($past(prot_bits) & ~prot_bits) == '0));

endmodule

// File: rtl/sg_wen_flag.sv
module sg_wen_flag (
    input  logic clk,
    input  logic rst,
    input  logic wen_set,
    input  logic op_valid,
    output logic wen
);

    always_ff @(posedge clk) begin
        if (rst)
            wen <= 1'b0;
        else if (wen_set)
            wen <= 1'b1;
        else if (op_valid)
            wen <= 1'b0;
    end

    assert_wen_consumed_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !wen_set) |=> !wen);

    assert_wen_armed_R6: assert property (@(posedge clk) disable iff (rst)
        wen_set |=> wen);

endmodule

// File: rtl/sg_op_check.sv
module sg_op_check
    import sg_pkg::*;
#(
    parameter int N  = NUM_SECTORS,
    parameter int AW = ADDR_W,
    parameter int KW = KIND_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [KW-1:0]   op_kind,
    input  logic [AW-1:0]   op_addr,
    input  logic            wen,
    input  logic [N-1:0]    prot_bits,
    output op_result_t      result
);

    logic [AW-1:0]    base;
    logic [IDX_W-1:0] sec;
    logic             allowed;
    logic             unused_low;

    assign base       = block_base(op_addr, op_kind);
    assign sec        = sector_of(base);
    assign unused_low = ^base[SECTOR_BITS-1:0];

    always_comb begin
        allowed = 1'b0;
        case (op_kind)
            OP_PROGRAM, OP_ERASE_4K, OP_ERASE_32K, OP_ERASE_64K:
                allowed = !prot_bits[sec];
            OP_ERASE_CHIP:
                allowed = (prot_bits == '0);
            default:
                allowed = 1'b0;
        endcase
        allowed = allowed && wen;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else begin
            result.valid <= op_valid;
            result.ok    <= op_valid && allowed;
        end
    end

    assert_result_follows_R9: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> result.valid);

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !result.valid);

    assert_needs_wen_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !wen) |=> !result.ok);

    assert_chip_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_ERASE_CHIP && (prot_bits != '0)) |=> !result.ok);

    assert_bad_kind_R11: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind > OP_ERASE_CHIP) |=> !result.ok);

endmodule

// File: rtl/sector_guard.sv
module sector_guard
    import sg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic                hw_lock,
    input  logic                wen_set,
    input  logic                op_valid,
    input  logic [KIND_W-1:0]   op_kind,
    input  logic [ADDR_W-1:0]   op_addr,
    input  logic [IDX_W-1:0]    stat_sector,
    output logic                stat_prot,
    output logic                res_valid,
    output logic                res_ok
);

    logic [NUM_SECTORS-1:0] prot_bits;
    logic                   wen;
    op_result_t             result;
    logic                   unused_cmd_low;

    assign unused_cmd_low = ^cmd_addr[SECTOR_BITS-1:0];

    sg_prot_map #(.N(NUM_SECTORS), .IW(IDX_W)) u_map (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (prot_cmd_e'(cmd_op)),
        .cmd_idx   (sector_of(cmd_addr)),
        .hw_lock   (hw_lock),
        .prot_bits (prot_bits)
    );

    sg_wen_flag u_wen (
        .clk      (clk),
        .rst      (rst),
        .wen_set  (wen_set),
        .op_valid (op_valid),
        .wen      (wen)
    );

    sg_op_check #(.N(NUM_SECTORS), .AW(ADDR_W), .KW(KIND_W)) u_check (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .wen       (wen),
        .prot_bits (prot_bits),
        .result    (result)
    );

    assign stat_prot = prot_bits[stat_sector];
    assign res_valid = result.valid;
    assign res_ok    = result.ok;

    assert_ok_implies_valid_R9: assert property (@(posedge clk) disable iff (rst)
        res_ok |-> res_valid);

endmodule

// File: tb/sector_guard_tb.sv
module sector_guard_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [19:0] cmd_addr = '0;
    logic        hw_lock = 1'b0;
    logic        wen_set = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [19:0] op_addr = '0;
    logic [3:0]  stat_sector = '0;
    logic        stat_prot;
    logic        res_valid;
    logic        res_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sector_guard u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .hw_lock(hw_lock), .wen_set(wen_set),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
        .stat_sector(stat_sector), .stat_prot(stat_prot),
        .res_valid(res_valid), .res_ok(res_ok)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reads all sixteen status bits through the status port
    task automatic read_map(output logic [15:0] m);
        for (int s = 0; s < 16; s++) begin
            stat_sector = 4'(s);
            #1;
            m[s] = stat_prot;
        end
    endtask

    task automatic cmd(input logic [1:0] code, input logic [19:0] addr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = code; cmd_addr = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic req(input string tag, input bit arm, input logic [2:0] kind,
                       input logic [19:0] addr, input bit exp_ok);
        if (arm) begin
            @(negedge clk);
            wen_set = 1'b1;
        end
        @(negedge clk);
        wen_set = 1'b0; op_valid = 1'b1; op_kind = kind; op_addr = addr;
        @(negedge clk);
        op_valid = 1'b0;
        chk(tag, "res_valid", 32'(res_valid), 32'd1);
        chk(tag, "res_ok", 32'(res_ok), 32'(exp_ok));
    endtask

    task automatic t_reset;
        logic [15:0] m;
        read_map(m);
        chk("R1", "map after reset", 32'(m), 32'h0000_FFFF);
        chk("R9", "res_valid idle", 32'(res_valid), 32'd0);
        req("R7", 1, 3'b000, 20'h3_0010, 1'b0);
    endtask

    task automatic t_single;
        logic [15:0] m;
        cmd(2'b01, 20'h5_1234);
        read_map(m);
        chk("R3", "unprotect sector 5", 32'(m), 32'h0000_FFDF);
        req("R7", 1, 3'b000, 20'h5_00FF, 1'b1);
        req("R7", 1, 3'b001, 20'h5_FABC, 1'b1);
        req("R7", 1, 3'b010, 20'h5_F000, 1'b1);
        req("R7", 1, 3'b011, 20'h5_8000, 1'b1);
        req("R7", 1, 3'b011, 20'h6_0000, 1'b0);
        req("R7", 1, 3'b001, 20'h4_FFFF, 1'b0);
        cmd(2'b00, 20'h5_0000);
        read_map(m);
        chk("R2", "reprotect sector 5", 32'(m), 32'h0000_FFFF);
        cmd(2'b01, 20'hA_0000);
        cmd(2'b00, 20'hB_0000);
        read_map(m);
        chk("R2", "protect already-set sector 11", 32'(m), 32'h0000_FBFF);
    endtask

    task automatic t_wen;
        req("R6", 0, 3'b000, 20'hA_0100, 1'b0);
        req("R6", 1, 3'b000, 20'hA_0100, 1'b1);
        req("R6", 0, 3'b000, 20'hA_0200, 1'b0);
        req("R6", 1, 3'b000, 20'h1_0000, 1'b0);
        req("R6", 0, 3'b000, 20'hA_0200, 1'b0);
        // strobe and request in the same cycle: request sees the old flag
        @(negedge clk);
        wen_set = 1'b1; op_valid = 1'b1; op_kind = 3'b000; op_addr = 20'hA_0300;
        @(negedge clk);
        wen_set = 1'b0; op_valid = 1'b0;
        chk("R6", "same-cycle arm res_ok", 32'(res_ok), 32'd0);
        req("R6", 0, 3'b000, 20'hA_0300, 1'b1);
    endtask

    task automatic t_global;
        logic [15:0] m;
        cmd(2'b11, 20'h0);
        read_map(m);
        chk("R4", "unprotect all", 32'(m), 32'h0000_0000);
        req("R8", 1, 3'b100, 20'h0, 1'b1);
        cmd(2'b00, 20'hF_0000);
        req("R8", 1, 3'b100, 20'h0, 1'b0);
        req("R7", 1, 3'b011, 20'hE_0000, 1'b1);
        cmd(2'b10, 20'h0);
        read_map(m);
        chk("R4", "protect all", 32'(m), 32'h0000_FFFF);
    endtask

    task automatic t_lock;
        logic [15:0] m;
        cmd(2'b11, 20'h0);
        cmd(2'b00, 20'h7_0000);
        hw_lock = 1'b1;
        cmd(2'b01, 20'h7_0000);
        read_map(m);
        chk("R5", "unprotect one under lock", 32'(m), 32'h0000_0080);
        cmd(2'b00, 20'h9_0000);
        cmd(2'b11, 20'h0);
        read_map(m);
        chk("R5", "protect then unprotect all under lock", 32'(m), 32'h0000_0280);
        cmd(2'b10, 20'h0);
        read_map(m);
        chk("R5", "protect all under lock", 32'(m), 32'h0000_FFFF);
        hw_lock = 1'b0;
        cmd(2'b01, 20'h7_0000);
        read_map(m);
        chk("R5", "unprotect after lock released", 32'(m), 32'h0000_FF7F);
    endtask

    task automatic t_kind;
        req("R11", 1, 3'b101, 20'h7_0000, 1'b0);
        req("R11", 1, 3'b110, 20'h7_0000, 1'b0);
        req("R11", 1, 3'b111, 20'h7_0000, 1'b0);
    endtask

    task automatic t_same_cycle;
        logic [15:0] m;
        @(negedge clk);
        wen_set = 1'b1;
        @(negedge clk);
        wen_set = 1'b0;
        op_valid = 1'b1; op_kind = 3'b001; op_addr = 20'h7_3000;
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 20'h7_0000;
        @(negedge clk);
        op_valid = 1'b0; cmd_valid = 1'b0;
        chk("R9", "decision uses pre-command map", 32'(res_ok), 32'd1);
        @(negedge clk);
        chk("R9", "single result pulse", 32'(res_valid), 32'd0);
        read_map(m);
        chk("R10", "status after same-cycle protect", 32'(m), 32'h0000_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_wen();
        t_global();
        t_lock();
        t_kind();
        t_same_cycle();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule